// File: doc/BRIEF.md
# Relocatable On-Chip RAM

This block is a small word-organised RAM on a host bus with 24-bit addresses and 16-bit data. Software chooses where the array appears in the memory map by writing a base register. The array can start on any 8 KB-aligned boundary. The base register sits in a small control window at a fixed address, and that window answers at all times.

After a master reset the array is disabled, because the base value left over from reset cannot be trusted. While disabled, the array ignores every bus address. The first write into the base field clears the disable flag, so the array appears at the programmed location. Software cannot set the flag again; only a reset does that.

Every access that the block claims (an array hit, or any word in the control window) gets a single-cycle acknowledge in the cycle after the request. Read data comes with that acknowledge. Accesses the block does not claim get no acknowledge, and the surrounding bus times them out.

Top module: `reloc_ram`

## Requirements
- R1: After reset the base register reads 0x0001: the base field is zero and the disable flag (bit 0) is set. The disable flag never becomes set again except by reset.
- R2: In the base register, bits 4:1 always read as zero. The value written to bit 0 is ignored; bit 0 reads back the disable flag.
- R3: A write to the base register with at least one byte lane enabled clears the disable flag. The upper lane loads base bits 10:3 from data bits 15:8. The lower lane loads base bits 2:0 from data bits 7:5. A write with no lane enabled changes nothing.
- R4: While the disable flag is set, an access outside the control window gets no acknowledge, and an array write leaves the array contents unchanged.
- R5: An array hit needs all three of these: address bits 23:13 equal the base field, the disable flag is clear, and the offset in address bits 12:0 is below RAM_BYTES (default 2048). An access that meets the first two but has a larger offset is a miss.
- R6: For every claimed request, bus_ack is high for exactly one cycle, the cycle after the request. For a read, bus_rdata carries the data in that same cycle. Whenever bus_ack is low, bus_rdata is zero.
- R7: An array write stores data bits 15:8 when bus_be[1] is set and data bits 7:0 when bus_be[0] is set. A lane that is not enabled keeps its old byte.
- R8: The control window is the 8 bytes at CTRL_ADDR (default 0xFFF880). The base register is at byte offset 4. The other window words read as zero and ignore writes. Every window access is acknowledged, whatever the state of the disable flag.
- R9: An access that hits neither the array nor the control window is never acknowledged.
- R10: Address bit 0 is ignored. An odd address reaches the same 16-bit word as the even address below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| bus_sel | input | 1 | Request valid for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_be | input | 2 | Byte lane enables: [1] selects bits 15:8, [0] selects bits 7:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | One-cycle acknowledge |

## Verification
The hardest state to reach from the ports is an array that already holds known data while its disable flag is set. Only that state shows that writes made while disabled are really dropped. The bench first enables the array and fills it. It then asserts master reset partway through the run, which leaves the array contents intact. Next it sends writes to the old base while the block is disabled. Finally it re-enables the block at the same base and reads back the original words. Random traffic then mixes in-range hits, offsets beyond the array end, foreign bases, odd addresses, partial byte enables and control-window reads.

// File: rtl/reloc_ram_pkg.sv
package reloc_ram_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int BASE_W = 11;
  localparam int OFS_W  = ADDR_W - BASE_W;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {TGT_NONE, TGT_ARRAY, TGT_CTRL} tgt_e;
  typedef enum logic [1:0] {RSP_NONE, RSP_ARR, RSP_REG} rsp_e;
endpackage

// File: rtl/ram_rst_sync.sv
module ram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ram_decode.sv
module ram_decode
  import reloc_ram_pkg::*;
#(
  parameter int                RAM_BYTES = 2048,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hFFF880,
  parameter int                BASE_WORD = 2,
  localparam int               WAW       = $clog2(RAM_BYTES / 2)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic              dis,
  output tgt_e              tgt,
  output logic              reg_hit,
  output logic [WAW-1:0]    idx
);
  localparam logic [OFS_W:0] LIMIT = (OFS_W + 1)'(RAM_BYTES);

  logic ctrl_match;
  logic arr_match;
  logic unused_bit0;

  assign unused_bit0 = addr[0];
  assign ctrl_match  = (addr[ADDR_W-1:3] == CTRL_ADDR[ADDR_W-1:3]);
  assign arr_match   = (addr[ADDR_W-1:OFS_W] == base) && !dis &&
                       ({1'b0, addr[OFS_W-1:0]} < LIMIT);

  // The control window wins when both match, so it stays reachable.
  always_comb begin
    if (ctrl_match)     tgt = TGT_CTRL;
    else if (arr_match) tgt = TGT_ARRAY;
    else                tgt = TGT_NONE;
  end

  assign reg_hit = ctrl_match && (addr[2:1] == 2'(BASE_WORD));
  assign idx     = addr[WAW:1];
endmodule

// File: rtl/ram_basereg.sv
module ram_basereg
  import reloc_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [BASE_W-1:0] base_q,
  output logic              dis_q
);
  logic [BASE_W-1:0] base_d;
  logic              dis_d;
  logic              upd;
  logic [4:0]        unused_low;

  assign unused_low = wdata[4:0];
  assign upd        = wr_en && (|be);

  always_comb begin
    base_d = base_q;
    dis_d  = dis_q;
    if (wr_en && be[1]) base_d[10:3] = wdata[15:8];
    if (wr_en && be[0]) base_d[2:0]  = wdata[7:5];
    if (upd)            dis_d        = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      dis_q  <= 1'b1;
    end else if (upd) begin
      base_q <= base_d;
      dis_q  <= dis_d;
    end
  end
endmodule

// File: rtl/ram_array.sv
module ram_array
  import reloc_ram_pkg::*;
#(
  parameter int  WORDS = 1024,
  localparam int WAW   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [LANES-1:0]  be,
  input  logic [WAW-1:0]    idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [WORDS];

    always_ff @(posedge clk) begin
      if (we && be[g]) mem[idx] <= wdata[8*g +: 8];
    end

    always_ff @(posedge clk) begin
      if (re) rdata_q[8*g +: 8] <= mem[idx];
    end
  end
endmodule

// File: rtl/ram_resp.sv
module ram_resp
  import reloc_ram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  tgt_e              tgt,
  input  logic              reg_hit,
  input  logic [BASE_W-1:0] base_q,
  input  logic              dis_q,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  logic              ack_d, ack_q;
  rsp_e              kind_d, kind_q;
  logic [DATA_W-1:0] regv_d, regv_q;

  always_comb begin
    ack_d  = sel && (tgt != TGT_NONE);
    kind_d = RSP_NONE;
    if (sel && !wr && tgt == TGT_ARRAY) kind_d = RSP_ARR;
    if (sel && !wr && tgt == TGT_CTRL)  kind_d = RSP_REG;
    regv_d = reg_hit ? {base_q, 4'b0000, dis_q} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      kind_q <= RSP_NONE;
      regv_q <= '0;
    end else begin
      ack_q  <= ack_d;
      kind_q <= kind_d;
      if (sel) regv_q <= regv_d;
    end
  end

  always_comb begin
    case (kind_q)
      RSP_ARR: rdata = arr_rdata;
      RSP_REG: rdata = regv_q;
      default: rdata = '0;
    endcase
  end

  assign ack = ack_q;
endmodule

// File: rtl/reloc_ram.sv
module reloc_ram
  import reloc_ram_pkg::*;
#(
  parameter int                RAM_BYTES = 2048,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hFFF880,
  localparam int               WORDS     = RAM_BYTES / 2,
  localparam int               WAW       = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [23:0]       bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_ack
);
  logic              rst_int_n;
  tgt_e              tgt;
  logic              reg_hit;
  logic              ctrl_hit;
  logic [WAW-1:0]    idx;
  logic [BASE_W-1:0] base_q;
  logic              dis_q;
  logic [DATA_W-1:0] arr_rdata;
  logic              arr_we, arr_re, reg_we;

  ram_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  ram_decode #(.RAM_BYTES(RAM_BYTES), .CTRL_ADDR(CTRL_ADDR), .BASE_WORD(2)) u_dec (
    .addr(bus_addr), .base(base_q), .dis(dis_q),
    .tgt(tgt), .reg_hit(reg_hit), .idx(idx)
  );

  assign ctrl_hit = (tgt == TGT_CTRL);
  assign arr_we   = bus_sel &&  bus_wr && (tgt == TGT_ARRAY);
  assign arr_re   = bus_sel && !bus_wr && (tgt == TGT_ARRAY);
  assign reg_we   = bus_sel &&  bus_wr && reg_hit;

  ram_basereg u_breg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_we), .be(bus_be),
    .wdata(bus_wdata), .base_q(base_q), .dis_q(dis_q)
  );

  ram_array #(.WORDS(WORDS)) u_arr (
    .clk(clk), .we(arr_we), .re(arr_re), .be(bus_be), .idx(idx),
    .wdata(bus_wdata), .rdata_q(arr_rdata)
  );

  ram_resp u_resp (
    .clk(clk), .rst_n(rst_int_n), .sel(bus_sel), .wr(bus_wr), .tgt(tgt),
    .reg_hit(reg_hit), .base_q(base_q), .dis_q(dis_q),
    .arr_rdata(arr_rdata), .ack(bus_ack), .rdata(bus_rdata)
  );
endmodule

// File: rtl/reloc_ram_chk.sv
module reloc_ram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [1:0]  bus_be,
  input logic        bus_ack,
  input logic [15:0] bus_rdata,
  input logic        ctrl_hit,
  input logic        reg_hit,
  input logic        dis_q,
  input logic [10:0] base_q
);
  a_r6_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_sel));

  a_r6_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> bus_rdata == 16'h0000);

  a_r3_write_enables: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && bus_wr && reg_hit && (|bus_be)) |-> !dis_q);

  a_r1_dis_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dis_q) |-> !dis_q);

  a_r3_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_sel && bus_wr && reg_hit) |-> $stable(base_q));

  a_r8_ctrl_always_acks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && ctrl_hit) |-> bus_ack);

  a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sel && !ctrl_hit && dis_q) |-> !bus_ack);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && $past(bus_sel && !bus_wr && reg_hit)) |-> bus_rdata[4:1] == 4'b0000);
endmodule

bind reloc_ram reloc_ram_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_be(bus_be), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
  .ctrl_hit(ctrl_hit), .reg_hit(reg_hit), .dis_q(dis_q), .base_q(base_q)
);

// File: tb/sim_reloc_ram.sv
`timescale 1ns/1ps
module sim_reloc_ram;
  localparam logic [23:0] CTRL = 24'hFFF880;
  localparam int          RAMB = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ack;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] mdl [1024];
  logic [10:0] base_m;
  logic        dis_m;

  always #2.5 clk = ~clk;

  reloc_ram u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int kind(input logic [23:0] a);
    if (a[23:3] == CTRL[23:3]) return 2;
    if (!dis_m && a[23:13] == base_m && a[12:0] < 13'(RAMB)) return 1;
    return 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    base_m = '0;
    dis_m = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One request, then one idle cycle to see the acknowledge drop.
  task automatic xfer(input logic wr, input logic [23:0] a, input logic [1:0] be,
                      input logic [15:0] wd, input string req);
    int k;
    logic [15:0] exp;
    logic ack1, ack2;
    logic [15:0] rd;
    k = kind(a);
    exp = 16'h0000;
    if (!wr && k == 1) exp = mdl[a[10:1]];
    if (!wr && k == 2 && a[2:1] == 2'd2) exp = {base_m, 4'b0000, dis_m};
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(posedge clk);
    #1;
    ack1 = bus_ack; rd = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
    @(posedge clk);
    #1;
    ack2 = bus_ack;
    check(ack1 == (k != 0), {req, " ack"}, 32'(ack1), 32'(k != 0));
    check(ack2 == 1'b0, {req, " R6 ack pulse"}, 32'(ack2), 0);
    if (!wr || k == 0) check(rd == exp, {req, " rdata"}, 32'(rd), 32'(exp));
    if (wr && k == 1) begin
      if (be[1]) mdl[a[10:1]][15:8] = wd[15:8];
      if (be[0]) mdl[a[10:1]][7:0] = wd[7:0];
    end
    if (wr && k == 2 && a[2:1] == 2'd2 && be != 0) begin
      if (be[1]) base_m[10:3] = wd[15:8];
      if (be[0]) base_m[2:0] = wd[7:5];
      dis_m = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] a;
    logic [1:0] be;
    logic [15:0] wd;
    int sel;
    void'($urandom(32'd4711));
    base_m = '0; dis_m = 1'b1;
    do_reset();
    // R1/R2: reset value of base register
    xfer(0, CTRL + 24'd4, 2'b11, 0, "R1 reset read");
    // R8: other window words read zero, always acked even while disabled
    xfer(0, CTRL, 2'b11, 0, "R8 window word0");
    xfer(1, CTRL + 24'd6, 2'b11, 16'hFFFF, "R8 window write other");
    xfer(0, CTRL + 24'd6, 2'b11, 0, "R8 window word3");
    // R4/R9: disabled array at base 0 gives no ack
    xfer(0, 24'h000010, 2'b11, 0, "R4 disabled read");
    // R3: no lane enabled -> no effect
    xfer(1, CTRL + 24'd4, 2'b00, 16'hFFFE, "R3 be0 write");
    xfer(0, CTRL + 24'd4, 2'b11, 0, "R3 after be0");
    // R3/R2: lower lane only, bit0 written as 1 ignored
    xfer(1, CTRL + 24'd4, 2'b01, 16'hFFFF, "R3 lower lane");
    xfer(0, CTRL + 24'd4, 2'b11, 0, "R2 readback");
    // full base 0x123 -> array at 0x246000
    xfer(1, CTRL + 24'd4, 2'b11, {11'h123, 5'b11111}, "R3 full base");
    xfer(0, CTRL + 24'd4, 2'b11, 0, "R3 readback");
    // fill array
    for (int i = 0; i < 1024; i++)
      xfer(1, {11'h123, 13'(2 * i)}, 2'b11, 16'($urandom), "R7 fill");
    // R5 boundaries
    xfer(0, {11'h123, 13'h07FE}, 2'b11, 0, "R5 last word");
    xfer(0, {11'h123, 13'h0800}, 2'b11, 0, "R5 past end");
    xfer(1, {11'h123, 13'h1FFE}, 2'b11, 16'h1234, "R5 top offset");
    xfer(0, {11'h122, 13'h0000}, 2'b11, 0, "R9 foreign base");
    // R10: odd address same word
    xfer(1, {11'h123, 13'h0021}, 2'b11, 16'hBEEF, "R10 odd write");
    xfer(0, {11'h123, 13'h0020}, 2'b11, 0, "R10 even read");
    // R7: partial lanes
    xfer(1, {11'h123, 13'h0040}, 2'b10, 16'hA5A5, "R7 upper lane");
    xfer(1, {11'h123, 13'h0042}, 2'b01, 16'h5A5A, "R7 lower lane");
    xfer(0, {11'h123, 13'h0040}, 2'b11, 0, "R7 upper read");
    xfer(0, {11'h123, 13'h0042}, 2'b11, 0, "R7 lower read");
    // random mix
    for (int i = 0; i < 800; i++) begin
      sel = int'($urandom_range(0, 9));
      wd = 16'($urandom);
      be = 2'($urandom);
      case (sel)
        0,1,2,3,4: a = {11'h123, 2'b00, 11'($urandom)};
        5:         a = {11'h123, 13'h0800 + 13'($urandom_range(0, 6143))};
        6:         a = {11'($urandom), 13'($urandom)};
        default:   a = CTRL + 24'($urandom_range(0, 7));
      endcase
      if (sel >= 7 && a[2:1] == 2'd2) xfer(0, a, be, wd, "R8 random window");
      else xfer(1'($urandom), a, be, wd, "R5 random");
    end
    // R4: reset keeps contents, disabled writes dropped
    do_reset();
    xfer(0, CTRL + 24'd4, 2'b11, 0, "R1 second reset");
    xfer(1, {11'h123, 13'h0100}, 2'b11, 16'h0BAD, "R4 disabled write");
    xfer(1, {11'h000, 13'h0100}, 2'b11, 16'h0BAD, "R4 disabled base0 write");
    xfer(1, CTRL + 24'd4, 2'b11, {11'h123, 5'b0}, "R3 re-enable");
    xfer(0, {11'h123, 13'h0100}, 2'b11, 0, "R4 contents kept");
    xfer(0, {11'h123, 13'h0102}, 2'b11, 0, "R4 contents kept 2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule